// File: doc/BRIEF.md
# Multi-size unsigned double-width divider

This unit divides an unsigned dividend of twice the selected operand width by an unsigned divisor of the selected width. The operand width can be 8, 16 or 32 bits. It returns a quotient and a remainder, each of the selected width. The quotient is truncated toward zero, so the remainder is always strictly below the divisor. A quotient wider than the operand width cannot be returned, and neither can any result for a zero divisor. In both cases the unit raises a divide-error indication in place of results, and it does so before any iteration starts.

A caller pulses `start_i` while the unit is idle. The unit captures the operands, runs a restoring shift-subtract loop that yields one quotient bit per cycle, and then adds wait cycles so that each width takes a fixed latency. It finishes with a one-cycle `done_o` pulse and registered results.

The controller has three named states:
- **IDLE**: waits for a request.
- **SHIFT**: iterates.
- **HOLD**: pads out the latency.

The transitions are:
- **accept**: IDLE→SHIFT, on a start with legal operands.
- **fault**: IDLE→IDLE, on a start with illegal operands. It pulses done and error.
- **bits_done**: SHIFT→HOLD, once all quotient bits are formed.
- **finish**: HOLD→IDLE, on the last latency cycle. It pulses done and loads the results.

Top module: `mdiv_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are 0, and `quo_o` and `rem_o` are 0.
- R2: On a successful divide, `quo_o` = floor(D / V) and `rem_o` = D mod V. D is the low 2W bits of `dividend_i` and V is the low W bits of `divisor_i`, both captured in the start cycle. The result bits above W are 0, and `rem_o` < V.
- R3: `pack_o` always equals {`rem_o`[7:0], `quo_o`[7:0]}. For the 8-bit width this is the remainder in the high byte and the quotient in the low byte.
- R4: The width code `size_i` selects the width: 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. With the start cycle counted as cycle 0, a successful divide raises `done_o` in cycle 17, 25 or 41 for 8, 16 or 32 bits. `busy_o` is 1 in every cycle in between and 0 in the done cycle.
- R5: A start with V = 0 raises `done_o` and `err_o` together in cycle 1, and `busy_o` never rises.
- R6: A start whose upper dividend half (bits [2W-1:W]) is at least V raises `done_o` and `err_o` in cycle 1. If the upper half is V−1, the divide is legal, including the maximal quotient 2^W−1.
- R7: When `err_o` is 1, `quo_o` and `rem_o` keep the values of the last successful divide.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The running divide's results are unchanged, and no extra `done_o` follows.
- R9: `done_o` lasts exactly one cycle, and `err_o` is 1 only in a cycle where `done_o` is 1.
- R10: Operand bits above 2W in the dividend and above W in the divisor have no effect. Operand changes after the start cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a divide (taken only when idle) |
| size_i | input | 2 | Width code: 0=8, 1=16, 2/3=32 bits |
| dividend_i | input | 64 | Double-width dividend, low 2W bits used |
| divisor_i | input | 32 | Divisor, low W bits used |
| busy_o | output | 1 | A divide is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide error, valid with done |
| quo_o | output | 32 | Quotient, zero-extended |
| rem_o | output | 32 | Remainder, zero-extended |
| pack_o | output | 16 | Remainder low byte over quotient low byte |

## Verification
The hardest situation to reach is the edge of the overflow test, where the upper dividend half is exactly one below the divisor. At that point the quotient is the largest legal value, and one step further becomes an error. Random operands almost never land there, so the stimulus builds the dividend from a chosen divisor: upper half V−1 or V, lower half all ones, at each of the three widths. Random cases are also drawn with the upper half forced below the divisor, so that most of them run the full loop. Each such case carries junk bits above the active width, and the operands are changed right after the start cycle.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

    typedef enum logic [1:0] {
        SZ_B  = 2'b00,
        SZ_H  = 2'b01,
        SZ_W  = 2'b10,
        SZ_WX = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_SHIFT = 2'b01,
        S_HOLD  = 2'b10
    } state_e;

    localparam int unsigned BW_B = 8;
    localparam int unsigned BW_H = 16;
    localparam int unsigned BW_W = 32;

endpackage

// File: rtl/mdiv_opsel.sv
module mdiv_opsel
    import mdiv_pkg::*;
#(
    parameter int unsigned MAX_W = BW_W,
    parameter int unsigned TW    = 6,
    parameter int unsigned LAT_B = 17,
    parameter int unsigned LAT_H = 25,
    parameter int unsigned LAT_W = 41
) (
    input  size_e              size,
    input  logic [2*MAX_W-1:0] dividend,
    input  logic [MAX_W-1:0]   divisor,
    output logic [MAX_W-1:0]   hi,
    output logic [MAX_W-1:0]   lo_al,
    output logic [MAX_W-1:0]   dvs,
    output logic [TW-1:0]      nbits,
    output logic [TW-1:0]      lat,
    output logic               fault
);

    always_comb begin
        hi    = '0;
        lo_al = '0;
        dvs   = '0;
        unique case (size)
            SZ_B: begin
                hi[BW_B-1:0]           = dividend[2*BW_B-1:BW_B];
                lo_al[MAX_W-1 -: BW_B] = dividend[BW_B-1:0];
                dvs[BW_B-1:0]          = divisor[BW_B-1:0];
                nbits                  = TW'(BW_B);
                lat                    = TW'(LAT_B);
            end
            SZ_H: begin
                hi[BW_H-1:0]           = dividend[2*BW_H-1:BW_H];
                lo_al[MAX_W-1 -: BW_H] = dividend[BW_H-1:0];
                dvs[BW_H-1:0]          = divisor[BW_H-1:0];
                nbits                  = TW'(BW_H);
                lat                    = TW'(LAT_H);
            end
            SZ_W, SZ_WX: begin
                hi    = dividend[2*MAX_W-1:MAX_W];
                lo_al = dividend[MAX_W-1:0];
                dvs   = divisor;
                nbits = TW'(MAX_W);
                lat   = TW'(LAT_W);
            end
        endcase
    end

    // upper half >= divisor covers both quotient overflow and zero divisor
    assign fault = (hi >= dvs);

endmodule

// File: rtl/mdiv_step.sv
module mdiv_step #(
    parameter int unsigned MAX_W = 32
) (
    input  logic [MAX_W-1:0] rem,
    input  logic [MAX_W-1:0] shq,
    input  logic [MAX_W-1:0] dvs,
    output logic [MAX_W-1:0] rem_nx,
    output logic [MAX_W-1:0] shq_nx
);

    logic [MAX_W:0] trial;
    logic [MAX_W:0] diff;
    logic           take;

    always_comb begin
        trial  = {rem, shq[MAX_W-1]};
        diff   = trial - {1'b0, dvs};
        take   = (trial >= {1'b0, dvs});
        rem_nx = take ? diff[MAX_W-1:0] : trial[MAX_W-1:0];
        shq_nx = {shq[MAX_W-2:0], take};
    end

endmodule

// File: rtl/mdiv_unit.sv
module mdiv_unit
    import mdiv_pkg::*;
#(
    parameter int unsigned LAT_B = 17,
    parameter int unsigned LAT_H = 25,
    parameter int unsigned LAT_W = 41
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [1:0]  size_i,
    input  logic [63:0] dividend_i,
    input  logic [31:0] divisor_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [31:0] quo_o,
    output logic [31:0] rem_o,
    output logic [15:0] pack_o
);

    localparam int unsigned MAX_W = BW_W;
    localparam int unsigned TW    = $clog2(LAT_W + 1);

    state_e           state_q, state_d;
    logic [TW-1:0]    tick_q, nb_q, last_q;
    logic [MAX_W-1:0] rem_q, shq_q, dvs_q;

    logic [MAX_W-1:0] op_hi, op_lo, op_dvs;
    logic [TW-1:0]    op_nb, op_lat;
    logic             op_fault;
    logic [MAX_W-1:0] st_rem, st_shq;
    logic             accept, finish;

    mdiv_opsel #(
        .MAX_W(MAX_W), .TW(TW),
        .LAT_B(LAT_B), .LAT_H(LAT_H), .LAT_W(LAT_W)
    ) u_opsel (
        .size     (size_e'(size_i)),
        .dividend (dividend_i),
        .divisor  (divisor_i),
        .hi       (op_hi),
        .lo_al    (op_lo),
        .dvs      (op_dvs),
        .nbits    (op_nb),
        .lat      (op_lat),
        .fault    (op_fault)
    );

    mdiv_step #(.MAX_W(MAX_W)) u_step (
        .rem    (rem_q),
        .shq    (shq_q),
        .dvs    (dvs_q),
        .rem_nx (st_rem),
        .shq_nx (st_shq)
    );

    assign accept = (state_q == S_IDLE) && start_i;
    assign finish = (state_q == S_HOLD) && (tick_q == last_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i && !op_fault)  state_d = S_SHIFT;
            S_SHIFT: if (tick_q == nb_q)        state_d = S_HOLD;
            S_HOLD:  if (tick_q == last_q)      state_d = S_IDLE;
            default:                            state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            nb_q   <= '0;
            last_q <= '0;
            rem_q  <= '0;
            shq_q  <= '0;
            dvs_q  <= '0;
        end else if (accept) begin
            tick_q <= TW'(1);
            nb_q   <= op_nb;
            last_q <= op_lat - TW'(1);
            rem_q  <= op_hi;
            shq_q  <= op_lo;
            dvs_q  <= op_dvs;
        end else if (state_q != S_IDLE) begin
            tick_q <= tick_q + TW'(1);
            if (state_q == S_SHIFT) begin
                rem_q <= st_rem;
                shq_q <= st_shq;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            quo_o  <= '0;
            rem_o  <= '0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            if (accept && op_fault) begin
                done_o <= 1'b1;
                err_o  <= 1'b1;
            end else if (finish) begin
                done_o <= 1'b1;
                quo_o  <= shq_q;
                rem_o  <= rem_q;
            end
        end
    end

    assign busy_o = (state_q != S_IDLE);
    assign pack_o = {rem_o[7:0], quo_o[7:0]};

endmodule

// File: rtl/mdiv_unit_chk.sv
module mdiv_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic [31:0] quo_o,
    input logic [31:0] rem_o,
    input logic [31:0] dvs_q
);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    a_r2_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (rem_o < dvs_q));

    a_r7_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(quo_o) && $stable(rem_o)));

    a_r4_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && !err_o));

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r5_err_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(start_i && !busy_o));

endmodule

bind mdiv_unit mdiv_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .quo_o   (quo_o),
    .rem_o   (rem_o),
    .dvs_q   (dvs_q)
);

// File: tb/mdiv_unit_tb_top.sv
module mdiv_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic [63:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        busy_o, done_o, err_o;
    logic [31:0] quo_o, rem_o;
    logic [15:0] pack_o;

    always #5 clk = ~clk;

    mdiv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .quo_o(quo_o), .rem_o(rem_o), .pack_o(pack_o)
    );

    typedef struct {
        logic [31:0] q;
        logic [31:0] r;
        logic        e;
        int unsigned lat;
        int unsigned t0;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int unsigned n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] mdl_q = '0, mdl_r = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // reference model from the requirements (R2, R4, R5, R6, R7)
    task automatic model(input logic [1:0] sz, input logic [63:0] dvd,
                         input logic [31:0] dvs, input string tag, output exp_t e);
        int unsigned w;
        logic [63:0] m, hi, lo, d, full;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m  = (64'd1 << w) - 64'd1;
        hi = (dvd >> w) & m;
        lo = dvd & m;
        d  = {32'd0, dvs} & m;
        e.tag = tag;
        if (d == 0 || hi >= d) begin
            e.e = 1'b1; e.q = mdl_q; e.r = mdl_r; e.lat = 1;
        end else begin
            full  = (hi << w) | lo;
            e.e   = 1'b0;
            e.q   = 32'(full / d);
            e.r   = 32'(full % d);
            e.lat = w + 9;
            mdl_q = e.q; mdl_r = e.r;
        end
    endtask

    // driver: one request, optional poke while busy
    task automatic run(input logic [1:0] sz, input logic [63:0] dvd,
                       input logic [31:0] dvs, input string tag, input bit poke);
        exp_t e;
        @(negedge clk);
        model(sz, dvd, dvs, tag, e);
        e.t0 = cyc;
        sb.push_back(e);
        size_i = sz; dividend_i = dvd; divisor_i = dvs; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dividend_i = {$urandom, $urandom};  // R10: late changes ignored
        divisor_i  = $urandom;
        size_i     = 2'($urandom);
        chk(busy_o == !e.e, e.e ? "R5" : "R4", {tag, " busy in cycle 1"},
            64'(busy_o), 64'(!e.e));
        if (poke && !e.e) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; size_i = 2'd0;
            dividend_i = 64'h0000_0000_0000_0102; divisor_i = 32'd1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        if (poke) repeat (50) @(negedge clk);  // R8: monitor flags any extra done
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8", "unexpected done", 64'(done_o), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(err_o == e.e, e.e ? "R6" : "R2", {e.tag, " err"}, 64'(err_o), 64'(e.e));
                chk(quo_o == e.q, e.e ? "R7" : "R2", {e.tag, " quotient"}, 64'(quo_o), 64'(e.q));
                chk(rem_o == e.r, e.e ? "R7" : "R2", {e.tag, " remainder"}, 64'(rem_o), 64'(e.r));
                chk(cyc - e.t0 == e.lat, e.e ? "R5" : "R4", {e.tag, " latency"},
                    64'(cyc - e.t0), 64'(e.lat));
                chk(!busy_o, "R4", {e.tag, " busy at done"}, 64'(busy_o), 64'd0);
                chk(pack_o == {e.r[7:0], e.q[7:0]}, "R3", {e.tag, " packed"},
                    64'(pack_o), 64'({e.r[7:0], e.q[7:0]}));
            end
        end
        if (rst_n && !done_o && n_chk > 5)
            if (err_o) chk(1'b0, "R9", "err without done", 64'(err_o), 64'd0);
    end

    // R9: done must drop after one cycle
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && done_prev && done_o)
            chk(1'b0, "R9", "done longer than one cycle", 64'(done_o), 64'd0);
        done_prev <= done_o;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R4 watchdog: actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1", "busy after reset", 64'(busy_o), 64'd0);
        chk(done_o == 1'b0, "R1", "done after reset", 64'(done_o), 64'd0);
        chk(err_o  == 1'b0, "R1", "err after reset",  64'(err_o),  64'd0);
        chk(quo_o  == '0,   "R1", "quo after reset",  64'(quo_o),  64'd0);
        chk(rem_o  == '0,   "R1", "rem after reset",  64'(rem_o),  64'd0);

        // R2 / R3 basic 8-bit
        run(2'd0, 64'd1000, 32'd7, "R2 b 1000/7", 1'b0);
        // R6 boundary: upper half = V-1, max quotient 255
        run(2'd0, 64'h06FF, 32'd7, "R6 b max", 1'b0);
        // R6 overflow and R7 hold
        run(2'd0, 64'h0700, 32'd7, "R6 b ovf", 1'b0);
        // R5 zero divisor
        run(2'd0, 64'h0012, 32'd0, "R5 b zero", 1'b0);
        // R10: junk above active bits
        run(2'd0, 64'hFFFF_FFFF_FFFF_1234, 32'hFFFF_FF56, "R10 b junk", 1'b0);
        // 16-bit
        run(2'd1, 64'd123456789, 32'd40000, "R2 h", 1'b0);
        run(2'd1, 64'h1233_FFFF, 32'h1234, "R6 h max", 1'b0);
        run(2'd1, 64'h1234_0000, 32'h1234, "R6 h ovf", 1'b0);
        run(2'd1, 64'hABCD_0000_0001_0000, 32'hFFFF_0000, "R5 h zero", 1'b0);
        // 32-bit, both codes
        run(2'd2, 64'h0123_4567_89AB_CDEF, 32'h8765_4321, "R2 w", 1'b0);
        run(2'd2, 64'hFFFF_FFFE_FFFF_FFFF, 32'hFFFF_FFFF, "R6 w max", 1'b0);
        run(2'd2, 64'hFFFF_FFFF_0000_0000, 32'hFFFF_FFFF, "R6 w ovf", 1'b0);
        run(2'd3, 64'h0000_0001_0000_0000, 32'd3, "R4 wx", 1'b0);
        run(2'd2, 64'd5, 32'd0, "R5 w zero", 1'b0);
        // R8: start while busy is ignored
        run(2'd1, 64'h0000_0000_00AB_CDEF, 32'h0123, "R8 poke h", 1'b1);
        run(2'd2, 64'h0000_0042_0000_0007, 32'h0000_1000, "R8 poke w", 1'b1);

        // random, mostly legal
        for (int i = 0; i < 60; i++) begin
            logic [1:0]  sz;
            int unsigned w;
            logic [63:0] m, hi, lo, dv, dvd;
            sz = 2'($urandom);
            w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
            m  = (64'd1 << w) - 64'd1;
            dv = {32'd0, $urandom} & m;
            if (dv == 0) dv = 64'd1;
            hi = (i % 5 == 4) ? ({32'd0, $urandom} & m) : ({32'd0, $urandom} % dv);
            lo = {32'd0, $urandom} & m;
            dvd = (hi << w) | lo | ({$urandom, $urandom} << (2 * w));
            run(sz, dvd, 32'(dv) | 32'({32'd0, $urandom} << w), "R2 rnd", 1'b0);
        end

        chk(sb.size() == 0, "R8", "scoreboard drained", 64'(sb.size()), 64'd0);
        summary();
        $finish;
    end

endmodule